// File: doc/BRIEF.md
# Potential-Function DRAM Request Scheduler

This block decides which request a shared DRAM bank serves next when several cores compete for it. Every core holds one request queue per warp, and every warp queue is split into requests that hit the currently open row and requests that miss it. The block sees only the occupancy counts of those queues, one tolerance value per core and whether the bank has a row open. It produces a registered grant that names a core, a warp and the hit or miss class. Request storage, DRAM timing and command sequencing live elsewhere.

The choice is made in two levels. First, the pending core with the smallest tolerance wins. Then, inside that core, the queue is picked whose service makes the largest drop in the core's potential. The potential is the sum of every queue length raised to the power one half. Serving a row hit from a queue of length L removes a whole unit from that queue. Serving a row miss removes only 1/m of a unit, where m is the miss-to-hit cost ratio. As a result, short queues and row hits are favoured, and long queues of misses are deferred.

All square roots are fixed-point constants. They are computed at elaboration into small tables indexed by queue length, so the data path only looks up values and compares them.

Top module: `pf_dram_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt_valid_o` is low.
- R2: When every queue of every core is empty, no grant is issued, even with `ready_i` high.
- R3: No grant is issued for a cycle in which `ready_i` is low, whatever the queues hold.
- R4: Among cores with an eligible request, the one with the smallest `tol_i` field wins (core c uses bits [c*TOL_W +: TOL_W]). On equal tolerance the lower core index wins.
- R5: A core with no eligible request is never chosen, however small its tolerance.
- R6: The hit queue of length L ≥ 1 has gain S(L) − S(L−1), where S(x) = floor(sqrt(x·2^16)) (FRAC = 8). The queue of the chosen core with the largest gain is granted. Queue (c, w, class) occupies `occ_i` bits [((c·N_WARP+w)·2+class)·QW +: QW], with class 0 = hit and class 1 = miss.
- R7: The miss queue of length L ≥ 1 has gain S(L) − floor(sqrt(floor((m·L−1)·2^16 / m))), with m = MISS_COST (default 2). Miss and hit gains compete in the same comparison, and `gnt_miss_o` = 1 marks a miss grant.
- R8: On equal gain, a hit queue beats a miss queue. Among queues of the same class, the lower warp index wins.
- R9: With `row_open_i` low, hit queues are not eligible, and a core holding only hits counts as having no eligible request.
- R10: The grant appears in the cycle after the edge at which `ready_i` and the queue state were sampled. It lasts one cycle per decision and drops after any edge at which `ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Command stage accepts a decision this cycle |
| row_open_i | input | 1 | Bank has an open row; hit queues eligible |
| occ_i | input | N_CORE·N_WARP·2·QW | Queue occupancy counts, layout per R6 |
| tol_i | input | N_CORE·TOL_W | Per-core tolerance, smaller is more urgent |
| gnt_valid_o | output | 1 | Grant valid for this cycle |
| gnt_core_o | output | max(1,clog2 N_CORE) | Granted core |
| gnt_warp_o | output | max(1,clog2 N_WARP) | Granted warp |
| gnt_miss_o | output | 1 | Granted class: 0 row hit, 1 row miss |

## Verification
Each grant is registered, so its result is due exactly one rising edge after the inputs are set. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, which is half a period after the only register has updated. The R10 check then drops `ready_i` and expects `gnt_valid_o` low one edge later. Directed scenarios give exact expected grants, and randomised vectors are compared with an enumerating model whose square roots come from a separate search.

// File: rtl/pf_sched_pkg.sv
package pf_sched_pkg;

   typedef enum logic {
      CLS_HIT  = 1'b0,
      CLS_MISS = 1'b1
   } req_cls_e;

   // Floor square root, bit by bit; operands stay below 2^48.
   function automatic int unsigned fx_isqrt(longint unsigned v);
      longint unsigned r;
      longint unsigned t;
      r = 64'd0;
      for (int b = 23; b >= 0; b--) begin
         t = r | (64'd1 << b);
         if (t * t <= v) r = t;
      end
      return r[31:0];
   endfunction

   // floor(sqrt(len) * 2^frac)
   function automatic int unsigned fx_root_len(int unsigned len, int unsigned frac);
      return fx_isqrt(64'(len) << (2 * frac));
   endfunction

   // floor(sqrt(len - 1/cost) * 2^frac)
   function automatic int unsigned fx_root_part(int unsigned len, int unsigned cost,
                                                int unsigned frac);
      longint unsigned num;
      num = ((64'(cost) * 64'(len) - 64'd1) << (2 * frac)) / 64'(cost);
      return fx_isqrt(num);
   endfunction

endpackage

// File: rtl/pf_gain_lut.sv
module pf_gain_lut
   import pf_sched_pkg::*;
#(
   parameter int QW           = 4,
   parameter int FRAC         = 8,
   parameter int MISS_COST    = 2,
   parameter bit MISS_VARIANT = 1'b0
) (
   input  logic [QW-1:0]   len_i,
   output logic [FRAC:0]   gain_o
);
   localparam int GW    = FRAC + 1;
   localparam int DEPTH = 1 << QW;

   if (QW < 1 || QW > 12) begin : g_bad_qw
      $error("pf_gain_lut: QW out of range");
   end
   if (MISS_COST < 2) begin : g_bad_cost
      $error("pf_gain_lut: MISS_COST must exceed one");
   end

   logic [GW-1:0] tbl [DEPTH];

   for (genvar l = 0; l < DEPTH; l++) begin : g_ent
      if (l == 0) begin : g_empty
         assign tbl[l] = '0;
      end else if (MISS_VARIANT) begin : g_miss
         localparam int unsigned VAL =
            fx_root_len(l, FRAC) - fx_root_part(l, MISS_COST, FRAC);
         assign tbl[l] = GW'(VAL);
      end else begin : g_hit
         localparam int unsigned VAL =
            fx_root_len(l, FRAC) - fx_root_len(l - 1, FRAC);
         assign tbl[l] = GW'(VAL);
      end
   end

   assign gain_o = tbl[len_i];

endmodule

// File: rtl/pf_core_pick.sv
module pf_core_pick #(
   parameter int N_CORE = 2,
   parameter int TOL_W  = 8,
   parameter int CW     = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
   input  logic [N_CORE-1:0]       pend_i,
   input  logic [N_CORE*TOL_W-1:0] tol_i,
   output logic                    found_o,
   output logic [CW-1:0]           core_o
);
   if (N_CORE < 1) begin : g_bad_cores
      $error("pf_core_pick: N_CORE must be positive");
   end

   logic [TOL_W-1:0] best_tol;

   // Strict less-than keeps the lower index on equal tolerance.
   always_comb begin
      found_o  = 1'b0;
      core_o   = '0;
      best_tol = '1;
      for (int c = 0; c < N_CORE; c++) begin
         if (pend_i[c] && (!found_o || tol_i[c*TOL_W +: TOL_W] < best_tol)) begin
            found_o  = 1'b1;
            core_o   = CW'(c);
            best_tol = tol_i[c*TOL_W +: TOL_W];
         end
      end
   end

endmodule

// File: rtl/pf_queue_pick.sv
module pf_queue_pick #(
   parameter int N_WARP    = 4,
   parameter int QW        = 4,
   parameter int FRAC      = 8,
   parameter int MISS_COST = 2,
   parameter int WW        = (N_WARP > 1) ? $clog2(N_WARP) : 1
) (
   input  logic [N_WARP*QW-1:0] hit_len_i,
   input  logic [N_WARP*QW-1:0] miss_len_i,
   input  logic                 hit_en_i,
   output logic                 found_o,
   output logic [WW-1:0]        warp_o,
   output logic                 miss_o
);
   localparam int GW = FRAC + 1;

   if (N_WARP < 1) begin : g_bad_warps
      $error("pf_queue_pick: N_WARP must be positive");
   end

   logic [GW-1:0] hit_gain  [N_WARP];
   logic [GW-1:0] miss_gain [N_WARP];
   logic [GW-1:0] best_gain;

   for (genvar w = 0; w < N_WARP; w++) begin : g_warp
      pf_gain_lut #(
         .QW(QW), .FRAC(FRAC), .MISS_COST(MISS_COST), .MISS_VARIANT(1'b0)
      ) u_hit_lut (
         .len_i (hit_len_i[w*QW +: QW]),
         .gain_o(hit_gain[w])
      );
      pf_gain_lut #(
         .QW(QW), .FRAC(FRAC), .MISS_COST(MISS_COST), .MISS_VARIANT(1'b1)
      ) u_miss_lut (
         .len_i (miss_len_i[w*QW +: QW]),
         .gain_o(miss_gain[w])
      );
   end

   // Hits are scanned before misses and only a strictly larger gain
   // displaces the holder, which yields hit-first, then lower-warp ties.
   always_comb begin
      found_o   = 1'b0;
      warp_o    = '0;
      miss_o    = 1'b0;
      best_gain = '0;
      for (int w = 0; w < N_WARP; w++) begin
         if (hit_en_i && hit_len_i[w*QW +: QW] != '0 &&
             (!found_o || hit_gain[w] > best_gain)) begin
            found_o   = 1'b1;
            warp_o    = WW'(w);
            miss_o    = 1'b0;
            best_gain = hit_gain[w];
         end
      end
      for (int w = 0; w < N_WARP; w++) begin
         if (miss_len_i[w*QW +: QW] != '0 &&
             (!found_o || miss_gain[w] > best_gain)) begin
            found_o   = 1'b1;
            warp_o    = WW'(w);
            miss_o    = 1'b1;
            best_gain = miss_gain[w];
         end
      end
   end

endmodule

// File: rtl/pf_dram_sched.sv
module pf_dram_sched
   import pf_sched_pkg::*;
#(
   parameter int N_CORE    = 2,
   parameter int N_WARP    = 4,
   parameter int QW        = 4,
   parameter int TOL_W     = 8,
   parameter int FRAC      = 8,
   parameter int MISS_COST = 2,
   parameter int CW        = (N_CORE > 1) ? $clog2(N_CORE) : 1,
   parameter int WW        = (N_WARP > 1) ? $clog2(N_WARP) : 1
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           ready_i,
   input  logic                           row_open_i,
   input  logic [N_CORE*N_WARP*2*QW-1:0]  occ_i,
   input  logic [N_CORE*TOL_W-1:0]        tol_i,
   output logic                           gnt_valid_o,
   output logic [CW-1:0]                  gnt_core_o,
   output logic [WW-1:0]                  gnt_warp_o,
   output logic                           gnt_miss_o
);
   localparam int OCC_W = N_CORE * N_WARP * 2 * QW;

   if (N_CORE < 1 || N_WARP < 1) begin : g_bad_shape
      $error("pf_dram_sched: N_CORE and N_WARP must be positive");
   end
   if (FRAC < 1 || FRAC > 12) begin : g_bad_frac
      $error("pf_dram_sched: FRAC out of range");
   end
   if (TOL_W < 1) begin : g_bad_tol
      $error("pf_dram_sched: TOL_W must be positive");
   end

   // ---------------- eligibility per core ----------------
   logic [N_CORE-1:0] core_pend;

   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      logic [N_WARP-1:0] warp_has;
      for (genvar w = 0; w < N_WARP; w++) begin : g_w
         localparam int HB = ((c * N_WARP + w) * 2) * QW;
         localparam int MB = HB + QW;
         assign warp_has[w] = (occ_i[MB +: QW] != '0) ||
                              (row_open_i && (occ_i[HB +: QW] != '0));
      end
      assign core_pend[c] = |warp_has;
   end

   // ---------------- core selection ----------------
   logic          core_found;
   logic [CW-1:0] sel_core;

   pf_core_pick #(
      .N_CORE(N_CORE), .TOL_W(TOL_W), .CW(CW)
   ) u_core_pick (
      .pend_i (core_pend),
      .tol_i  (tol_i),
      .found_o(core_found),
      .core_o (sel_core)
   );

   // ---------------- queue lengths of selected core ----------------
   logic [N_WARP*QW-1:0] sel_hit_len;
   logic [N_WARP*QW-1:0] sel_miss_len;

   always_comb begin
      for (int w = 0; w < N_WARP; w++) begin
         sel_hit_len[w*QW +: QW]  = occ_i[((int'(sel_core) * N_WARP + w) * 2) * QW +: QW];
         sel_miss_len[w*QW +: QW] = occ_i[((int'(sel_core) * N_WARP + w) * 2 + 1) * QW +: QW];
      end
   end

   // ---------------- queue selection ----------------
   logic          q_found;
   logic [WW-1:0] sel_warp;
   logic          sel_miss;

   pf_queue_pick #(
      .N_WARP(N_WARP), .QW(QW), .FRAC(FRAC), .MISS_COST(MISS_COST), .WW(WW)
   ) u_queue_pick (
      .hit_len_i (sel_hit_len),
      .miss_len_i(sel_miss_len),
      .hit_en_i  (row_open_i),
      .found_o   (q_found),
      .warp_o    (sel_warp),
      .miss_o    (sel_miss)
   );

   // ---------------- grant register ----------------
   logic issue;
   assign issue = ready_i && core_found && q_found;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gnt_valid_o <= 1'b0;
         gnt_core_o  <= '0;
         gnt_warp_o  <= '0;
         gnt_miss_o  <= 1'b0;
      end else begin
         gnt_valid_o <= issue;
         if (issue) begin
            gnt_core_o <= sel_core;
            gnt_warp_o <= sel_warp;
            gnt_miss_o <= sel_miss;
         end
      end
   end

   // ---------------- assertions ----------------
   function automatic logic [QW-1:0] len_at(logic [OCC_W-1:0] v, logic [CW-1:0] c,
                                             logic [WW-1:0] w, logic m);
      return v[((int'(c) * N_WARP + int'(w)) * 2 + int'(m)) * QW +: QW];
   endfunction

   AST_GNT_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_valid_o |-> $past(ready_i)); // R3

   AST_GNT_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_valid_o |-> (len_at($past(occ_i), gnt_core_o, gnt_warp_o, gnt_miss_o) != '0)); // R5

   AST_EMPTY_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(occ_i) == '0) |-> !gnt_valid_o); // R2

   AST_HIT_NEEDS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_valid_o && !gnt_miss_o) |-> $past(row_open_i)); // R9

   AST_CORE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_valid_o |-> (int'(gnt_core_o) < N_CORE)); // R4

endmodule

// File: tb/pf_dram_sched_tb.sv
`timescale 1ns/1ps
module pf_dram_sched_tb_top;
   localparam int NC = 2;
   localparam int NW = 4;
   localparam int QW = 4;
   localparam int TW = 8;
   localparam int FR = 8;
   localparam int MC = 2;
   localparam int OW = NC * NW * 2 * QW;
   localparam int MAXL = (1 << QW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ready = 1'b0;
   logic          row_open = 1'b1;
   logic [OW-1:0] occ = '0;
   logic [NC*TW-1:0] tol = '0;
   logic          g_valid;
   logic [0:0]    g_core;
   logic [1:0]    g_warp;
   logic          g_miss;

   int n_vec = 0;
   int n_bad = 0;
   int hit_g  [MAXL+1];
   int miss_g [MAXL+1];

   always #10 clk = ~clk;   // 50 MHz

   pf_dram_sched #(
      .N_CORE(NC), .N_WARP(NW), .QW(QW), .TOL_W(TW), .FRAC(FR), .MISS_COST(MC)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ready_i(ready), .row_open_i(row_open),
      .occ_i(occ), .tol_i(tol),
      .gnt_valid_o(g_valid), .gnt_core_o(g_core), .gnt_warp_o(g_warp),
      .gnt_miss_o(g_miss)
   );

   // Square root by linear search, independent of the design's method.
   function automatic int slow_root(longint v);
      int r = 0;
      while (longint'(r + 1) * longint'(r + 1) <= v) r++;
      return r;
   endfunction

   task automatic build_gains();
      longint one = longint'(1) << (2 * FR);
      hit_g[0] = 0; miss_g[0] = 0;
      for (int l = 1; l <= MAXL; l++) begin
         hit_g[l]  = slow_root(l * one) - slow_root((l - 1) * one);
         miss_g[l] = slow_root(l * one) - slow_root(((MC * l - 1) * one) / MC);
      end
   endtask

   function automatic int qlen(int c, int w, int m);
      return int'(occ[((c * NW + w) * 2 + m) * QW +: QW]);
   endfunction

   task automatic set_q(int c, int w, int m, int l);
      occ[((c * NW + w) * 2 + m) * QW +: QW] = QW'(l);
   endtask

   task automatic model(output bit v, output int ec, output int ew, output bit em);
      int best_t = -1;
      int best_g;
      v = 0; ec = 0; ew = 0; em = 0;
      for (int c = 0; c < NC; c++) begin
         bit has = 0;
         for (int w = 0; w < NW; w++)
            if (qlen(c, w, 1) != 0 || (row_open && qlen(c, w, 0) != 0)) has = 1;
         if (has && (best_t < 0 || int'(tol[c*TW +: TW]) < best_t)) begin
            best_t = int'(tol[c*TW +: TW]);
            ec = c;
         end
      end
      if (best_t < 0) return;
      v = 1; best_g = -1;
      for (int w = 0; w < NW; w++)
         if (row_open && qlen(ec, w, 0) != 0 && hit_g[qlen(ec, w, 0)] > best_g) begin
            best_g = hit_g[qlen(ec, w, 0)]; ew = w; em = 0;
         end
      for (int w = 0; w < NW; w++)
         if (qlen(ec, w, 1) != 0 && miss_g[qlen(ec, w, 1)] > best_g) begin
            best_g = miss_g[qlen(ec, w, 1)]; ew = w; em = 1;
         end
   endtask

   // Inputs are already set; wait one edge, sample on the falling edge.
   task automatic expect_gnt(string tag, bit v, int c, int w, bit m);
      @(posedge clk); @(negedge clk);
      n_vec++;
      if (g_valid !== v || (v && (int'(g_core) != c || int'(g_warp) != w || g_miss !== m))) begin
         n_bad++;
         $display("FAIL %s: got v=%0b c=%0d w=%0d m=%0b, expected v=%0b c=%0d w=%0d m=%0b",
                  tag, g_valid, g_core, g_warp, g_miss, v, c, w, m);
      end
   endtask

   task automatic t_reset();
      n_vec++;
      if (g_valid !== 1'b0) begin
         n_bad++; $display("FAIL R1: valid in reset got %0b expected 0", g_valid);
      end
      rst_n = 1'b1;
      expect_gnt("R1", 0, 0, 0, 0);
   endtask

   task automatic t_empty();
      occ = '0; ready = 1; row_open = 1;
      expect_gnt("R2", 0, 0, 0, 0);
   endtask

   task automatic t_not_ready();
      occ = '0; set_q(0, 2, 0, 3); ready = 0;
      expect_gnt("R3", 0, 0, 0, 0);
      ready = 1;
   endtask

   task automatic t_tolerance();
      occ = '0; set_q(0, 0, 0, 1); set_q(1, 3, 1, 2);
      tol = {8'd3, 8'd9};
      expect_gnt("R4 lowest tolerance", 1, 1, 3, 1);
      tol = {8'd5, 8'd5};
      expect_gnt("R4 tie lower core", 1, 0, 0, 0);
   endtask

   task automatic t_skip_empty();
      occ = '0; set_q(1, 1, 0, 4);
      tol = {8'd200, 8'd1};
      expect_gnt("R5 empty core skipped", 1, 1, 1, 0);
   endtask

   task automatic t_hit_gain();
      occ = '0; tol = {8'd50, 8'd10};
      set_q(0, 0, 0, 5); set_q(0, 1, 0, 1); set_q(0, 2, 0, 3);
      expect_gnt("R6 shortest hit", 1, 0, 1, 0);
   endtask

   task automatic t_miss_gain();
      occ = '0; tol = {8'd50, 8'd10};
      set_q(0, 0, 1, 4); set_q(0, 2, 1, 1);
      expect_gnt("R7 miss gains", 1, 0, 2, 1);
      occ = '0; set_q(0, 0, 0, 3); set_q(0, 1, 1, 1);   // hit 81 vs miss 75
      expect_gnt("R7 hit beats miss", 1, 0, 0, 0);
      occ = '0; set_q(0, 0, 0, 4); set_q(0, 1, 1, 1);   // hit 69 vs miss 75
      expect_gnt("R7 miss beats long hit", 1, 0, 1, 1);
   endtask

   task automatic t_ties();
      occ = '0; tol = {8'd50, 8'd10};
      set_q(0, 3, 0, 2); set_q(0, 1, 0, 2);
      expect_gnt("R8 lower warp", 1, 0, 1, 0);
      occ = '0; set_q(0, 0, 1, 3); set_q(0, 2, 1, 3);
      expect_gnt("R8 lower warp miss", 1, 0, 0, 1);
   endtask

   task automatic t_row_closed();
      occ = '0; tol = {8'd50, 8'd10}; row_open = 0;
      set_q(0, 0, 0, 1); set_q(0, 3, 1, 6);
      expect_gnt("R9 hits ignored", 1, 0, 3, 1);
      occ = '0; set_q(0, 2, 0, 1); set_q(1, 0, 1, 2);
      expect_gnt("R9 hit-only core skipped", 1, 1, 0, 1);
      occ = '0; set_q(0, 2, 0, 1);
      expect_gnt("R9 no eligible", 0, 0, 0, 0);
      row_open = 1;
   endtask

   task automatic t_one_cycle();
      occ = '0; tol = {8'd50, 8'd10}; set_q(1, 2, 0, 1); ready = 1;
      expect_gnt("R10 grant next cycle", 1, 1, 2, 0);
      ready = 0;
      expect_gnt("R10 drops without ready", 0, 0, 0, 0);
      ready = 1;
   endtask

   task automatic t_random();
      bit v; int c; int w; bit m;
      for (int i = 0; i < 400; i++) begin
         for (int q = 0; q < NC * NW * 2; q++)
            occ[q*QW +: QW] = ($urandom % 3 == 0) ? QW'($urandom % (MAXL + 1)) : '0;
         tol = {8'($urandom % 4), 8'($urandom % 4)};
         row_open = ($urandom % 4) != 0;
         ready = 1;
         model(v, c, w, m);
         expect_gnt("R6/R7/R8 random vs model", v, c, w, m);
      end
   endtask

   initial begin
      build_gains();
      repeat (3) @(negedge clk);
      t_reset();
      t_empty();
      t_not_ready();
      t_tolerance();
      t_skip_empty();
      t_hit_gain();
      t_miss_gain();
      t_ties();
      t_row_closed();
      t_one_cycle();
      t_random();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule